// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA

This block moves received frames from a byte stream into system memory through a circular chain of descriptors. Every descriptor occupies four consecutive 32-bit words. Word 0 holds status and the hand-over flag, word 1 holds the usable buffer size, word 2 holds the buffer address and word 3 holds the address of the following descriptor. The engine reads a descriptor and checks whether it owns it. It then accepts a whole frame into an internal staging store. Only after the frame is complete does it copy the bytes to the buffer. Finally it writes back a status word that returns the descriptor to software, and it moves on through the next pointer.

Software builds the chain, places the address of the first descriptor on `desc_base` and raises both `dma_start` and `rx_enable`. Software recycles a descriptor by setting its hand-over bit again. The engine waits on a descriptor it does not own by re-reading it at a fixed interval. While it waits it holds the frame input off. When software drops either control input, the engine completes any frame it has begun and then goes idle. The next start reloads the chain position from `desc_base`.

Top module: `rx_desc_dma`

## Requirements
- R1: While reset is high, and in the cycle after it, the block issues no memory request, holds `in_ready` low and reports `dma_busy` low.
- R2: When the engine leaves idle, it reloads its chain position from `desc_base` and reads the descriptor with four single-word reads at offsets 0, 4, 8 and 12, one per cycle, starting the cycle after the start. Each memory address it issues is word aligned.
- R3: A descriptor whose status bit 31 is 0 is not used. `in_ready` stays low and the engine re-reads the descriptor every POLL_GAP idle cycles until bit 31 reads 1.
- R4: No buffer write happens until the frame's last byte has been accepted. Frame byte k is stored at buffer address + k, little-endian within each word (byte k in bits 8*(k mod 4)+7 : 8*(k mod 4)).
- R5: After the copy, the engine writes the status word of the descriptor once. The written word has bit 31 = 0, bit 30 = 0, bits 29:16 = the number of bytes stored and bits 15:2 = 0.
- R6: The byte limit is the smaller of control word bits 13:0 and the staging capacity. Bytes past the limit are discarded and never written, and status bit 0 is set exactly when the frame was longer than the limit.
- R7: Status bit 1 is set exactly when the received frame length (all bytes, stored or not) is below MIN_FRAME (64). A frame of exactly 64 bytes is not flagged.
- R8: After a write-back, the engine fetches next from the address in word 3 of the descriptor just finished, so a chain that links back to its first entry is reused in order.
- R9: If `dma_start` drops while a frame is in progress, that frame is completed and written back. After that, no memory request is made, the next descriptor is untouched and `dma_busy` falls.
- R10: The engine runs only while both `dma_start` and `rx_enable` are high. With either one low and the engine idle, it makes no memory request.
- R11: Every write carries byte enables. The last buffer word of a frame enables only the lanes that hold stored bytes (1 byte: 0001, 2: 0011, 3: 0111, 4: 1111), and the bytes that follow keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_start | input | 1 | Run request |
| rx_enable | input | 1 | Receive enable; needed together with `dma_start` |
| desc_base | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | Memory request, one word per cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| dma_busy | output | 1 | Engine not idle |

## Verification
The bench sends frames whose lengths fall on each side of the runt threshold and of the per-descriptor size. This tells a status word that counts stored bytes apart from one that counts received bytes, and it shows whether the truncation and runt flags are independent. Odd sizes and lengths that end part-way through a word test the lane enables, because the guard bytes placed after each buffer must survive. The descriptors are linked out of address order and a frame is sent into a descriptor that is not yet handed over, so the test can tell pointer-following from sequential stepping and can tell polling from data loss. A stop raised in mid-frame, followed by a restart, separates finishing the current frame from aborting it and shows whether the start position is reloaded from the base.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int LEN_W     = 14;   // status length field width
    localparam int OWN_POS   = 31;   // hand-over bit
    localparam int LEN_LSB   = 16;   // status length field position
    localparam int RUNT_POS  = 1;
    localparam int TRUNC_POS = 0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_POLL,
        PH_RECV,
        PH_COPY,
        PH_STAT
    } phase_t;

    // descriptor image, word 0 in the low bits
    typedef struct packed {
        logic [31:0] next;
        logic [31:0] bufa;
        logic [31:0] ctrl;
        logic [31:0] stat;
    } desc_t;

    // lanes used by a final word holding rem bytes (0 means a full word)
    function automatic logic [3:0] tail_lanes(input logic [1:0] rem);
        case (rem)
            2'd1:    return 4'b0001;
            2'd2:    return 4'b0011;
            2'd3:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] cap_len(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                                input logic runt,
                                                input logic trunc);
        logic [31:0] s;
        s = '0;
        s[LEN_LSB +: LEN_W] = len;
        s[RUNT_POS]         = runt;
        s[TRUNC_POS]        = trunc;
        return s;
    endfunction

endpackage

// File: rtl/rxdma_stage.sv
// Whole-frame staging store: packs accepted bytes into words up to a limit,
// counts every byte seen and remembers whether any were dropped.
module rxdma_stage import rxdma_pkg::*; #(
    parameter int WORDS = 512,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             accept_en,
    input  logic [LEN_W-1:0] limit,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             take,
    output logic             frame_done,
    output logic [LEN_W-1:0] stored,
    output logic [LEN_W:0]   seen,
    output logic             trunc,
    input  logic [IW-1:0]    rd_idx,
    output logic [31:0]      rd_word
);

    logic [3:0][7:0] store [WORDS];
    logic            room;

    assign in_ready   = accept_en;
    assign take       = in_valid & accept_en;
    assign frame_done = take & in_last;
    assign room       = stored < limit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stored <= '0;
            seen   <= '0;
            trunc  <= 1'b0;
        end else if (take) begin
            if (seen != '1)
                seen <= seen + 1'b1;
            if (room)
                stored <= stored + 1'b1;
            else
                trunc <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take && room)
            store[stored[IW+1:2]][stored[1:0]] <= in_data;
    end

    assign rd_word = store[rd_idx];

endmodule

// File: rtl/rxdma_seq.sv
// Descriptor walker: fetch, ownership poll, receive window, copy, write-back.
module rxdma_seq import rxdma_pkg::*; #(
    parameter int AW          = 32,
    parameter int STAGE_WORDS = 512,
    parameter int POLL_GAP    = 64,
    parameter int MIN_FRAME   = 64,
    localparam int IW         = $clog2(STAGE_WORDS),
    localparam int STAGE_B    = STAGE_WORDS * 4,
    localparam int PW         = $clog2(POLL_GAP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [AW-1:0]    desc_base,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic [31:0]      mem_rdata,
    output logic             stage_clr,
    output logic             accept_en,
    output logic [LEN_W-1:0] limit,
    input  logic             take,
    input  logic             frame_done,
    input  logic [LEN_W-1:0] stored,
    input  logic [LEN_W:0]   seen,
    input  logic             trunc,
    output logic [IW-1:0]    rd_idx,
    input  logic [31:0]      rd_word,
    output phase_t           phase,
    output desc_t            desc,
    output logic             busy
);

    logic [AW-1:0]    ptr;
    logic [2:0]       fidx;
    logic [PW-1:0]    pcnt;
    logic [LEN_W-1:0] widx;
    logic [LEN_W-1:0] nwords;
    logic             last_w;
    logic             owned;
    logic             desc_unused;

    assign owned       = desc.stat[OWN_POS];
    assign nwords      = (stored + LEN_W'(3)) >> 2;
    assign last_w      = (widx == nwords - 1'b1);
    assign limit       = cap_len(desc.ctrl[LEN_W-1:0], LEN_W'(STAGE_B));
    assign rd_idx      = widx[IW-1:0];
    assign accept_en   = (phase == PH_RECV);
    assign stage_clr   = (phase == PH_FETCH) && (fidx == 3'd4) && run && owned;
    assign busy        = (phase != PH_IDLE);
    assign desc_unused = ^{desc.ctrl[31:LEN_W], desc.stat[30:0]};

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        mem_be    = '0;
        case (phase)
            PH_FETCH: begin
                if (fidx < 3'd4) begin
                    mem_req  = 1'b1;
                    mem_addr = ptr + AW'({fidx[1:0], 2'b00});
                end
            end
            PH_COPY: begin
                if (stored != '0) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = AW'(desc.bufa) + AW'({widx, 2'b00});
                    mem_wdata = rd_word;
                    mem_be    = last_w ? tail_lanes(stored[1:0]) : 4'b1111;
                end
            end
            PH_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr;
                mem_wdata = pack_status(stored, seen < (LEN_W+1)'(MIN_FRAME), trunc);
                mem_be    = 4'b1111;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            ptr   <= '0;
            fidx  <= '0;
            pcnt  <= '0;
            widx  <= '0;
            desc  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (run) begin
                        ptr   <= desc_base;
                        fidx  <= '0;
                        phase <= PH_FETCH;
                    end
                end
                PH_FETCH: begin
                    fidx <= fidx + 1'b1;
                    case (fidx)
                        3'd1: desc.stat <= mem_rdata;
                        3'd2: desc.ctrl <= mem_rdata;
                        3'd3: desc.bufa <= mem_rdata;
                        3'd4: desc.next <= mem_rdata;
                        default: ;
                    endcase
                    if (fidx == 3'd4) begin
                        if (!run)
                            phase <= PH_IDLE;
                        else if (owned)
                            phase <= PH_RECV;
                        else begin
                            pcnt  <= '0;
                            phase <= PH_POLL;
                        end
                    end
                end
                PH_POLL: begin
                    pcnt <= pcnt + 1'b1;
                    if (!run)
                        phase <= PH_IDLE;
                    else if (pcnt == PW'(POLL_GAP - 1)) begin
                        fidx  <= '0;
                        phase <= PH_FETCH;
                    end
                end
                PH_RECV: begin
                    if (frame_done) begin
                        widx  <= '0;
                        phase <= PH_COPY;
                    end else if (!run && seen == '0 && !take)
                        phase <= PH_IDLE;
                end
                PH_COPY: begin
                    if (stored == '0 || last_w)
                        phase <= PH_STAT;
                    else
                        widx <= widx + 1'b1;
                end
                PH_STAT: begin
                    ptr   <= AW'(desc.next);
                    fidx  <= '0;
                    phase <= run ? PH_FETCH : PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma import rxdma_pkg::*; #(
    parameter int AW          = 32,
    parameter int STAGE_WORDS = 512,
    parameter int POLL_GAP    = 64,
    parameter int MIN_FRAME   = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dma_start,
    input  logic          rx_enable,
    input  logic [AW-1:0] desc_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic [31:0]   mem_rdata,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          dma_busy
);

    localparam int IW = $clog2(STAGE_WORDS);

    logic             run;
    logic             stage_clr;
    logic             accept_en;
    logic [LEN_W-1:0] limit;
    logic             take;
    logic             frame_done;
    logic [LEN_W-1:0] stored;
    logic [LEN_W:0]   seen;
    logic             trunc;
    logic [IW-1:0]    rd_idx;
    logic [31:0]      rd_word;
    phase_t           phase_w;
    desc_t            desc_w;

    assign run = dma_start & rx_enable;

    rxdma_stage #(.WORDS(STAGE_WORDS)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .clr        (stage_clr),
        .accept_en  (accept_en),
        .limit      (limit),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .take       (take),
        .frame_done (frame_done),
        .stored     (stored),
        .seen       (seen),
        .trunc      (trunc),
        .rd_idx     (rd_idx),
        .rd_word    (rd_word)
    );

    rxdma_seq #(
        .AW          (AW),
        .STAGE_WORDS (STAGE_WORDS),
        .POLL_GAP    (POLL_GAP),
        .MIN_FRAME   (MIN_FRAME)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .desc_base  (desc_base),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be),
        .mem_rdata  (mem_rdata),
        .stage_clr  (stage_clr),
        .accept_en  (accept_en),
        .limit      (limit),
        .take       (take),
        .frame_done (frame_done),
        .stored     (stored),
        .seen       (seen),
        .trunc      (trunc),
        .rd_idx     (rd_idx),
        .rd_word    (rd_word),
        .phase      (phase_w),
        .desc       (desc_w),
        .busy       (dma_busy)
    );

endmodule

// File: rtl/rxdma_chk.sv
module rxdma_chk import rxdma_pkg::*; #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input phase_t        phase,
    input desc_t         cur_desc,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic [3:0]    mem_be,
    input logic          in_ready,
    input logic          busy
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!mem_req && !in_ready && !busy)); // R1

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

    AST_NO_INPUT_UNOWNED: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> cur_desc.stat[OWN_POS]); // R3

    AST_NO_WRITE_IN_RECV: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RECV) |-> !mem_req); // R4

    AST_HANDBACK: assert property (@(posedge clk) disable iff (rst)
        (mem_we && phase == PH_STAT) |-> (!mem_wdata[OWN_POS] &&
            mem_wdata[LEN_LSB +: LEN_W] <= cur_desc.ctrl[LEN_W-1:0])); // R5

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (mem_we && phase == PH_COPY) |->
            ((mem_addr - AW'(cur_desc.bufa)) < AW'(cur_desc.ctrl[LEN_W-1:0]))); // R6

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !in_ready)); // R10

    AST_LANES_SET: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_be != 4'b0000)); // R11

endmodule

bind rx_desc_dma rxdma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase_w),
    .cur_desc  (desc_w),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .in_ready  (in_ready),
    .busy      (dma_busy)
);

// File: tb/rx_desc_dma_test.sv
module rx_desc_dma_test;

    localparam int AW   = 32;
    localparam int POLL = 16;
    localparam int BASE = 32'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dma_start = 1'b0;
    logic          rx_enable = 1'b0;
    logic [AW-1:0] desc_base = BASE;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic [31:0]   mem_rdata = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          in_ready, dma_busy;

    always #2 clk = ~clk;

    rx_desc_dma #(.AW(AW), .POLL_GAP(POLL)) uut (
        .clk(clk), .rst(rst), .dma_start(dma_start), .rx_enable(rx_enable),
        .desc_base(desc_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .dma_busy(dma_busy)
    );

    // word memory model, one-cycle read latency
    logic [31:0] mem [0:1023];
    int req_cnt = 0, wr_cnt = 0, base_rd = 0;

    always @(posedge clk) begin
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
                if (mem_addr == BASE) base_rd <= base_rd + 1;
            end
        end
    end

    int total = 0, bad = 0;
    int descs [3] = '{32'h40, 32'h60, 32'h50};
    int bufs  [3] = '{32'h100, 32'h400, 32'h700};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int f, input int k);
        return 8'(f * 37 + k * 13 + 5);
    endfunction

    function automatic logic [7:0] get_byte(input int a);
        return mem[a / 4][8 * (a % 4) +: 8];
    endfunction

    task automatic put_byte(input int a, input logic [7:0] v);
        mem[a / 4][8 * (a % 4) +: 8] = v;
    endtask

    function automatic logic [31:0] exp_status(input int size, input int len);
        int lim, st;
        lim = size & 16'h3FFF;
        if (lim > 2048) lim = 2048;
        st = (len < lim) ? len : lim;
        return (32'(st) << 16) | ((len < 64) ? 32'h2 : 32'h0) | ((len > lim) ? 32'h1 : 32'h0);
    endfunction

    task automatic run_frame(input int slot, input int size, input int len, input int fno,
                             input string req, input int stop_at, input bit mid);
        int d, b, k, w0, t, st;
        bit mid_done, ok;
        logic [31:0] es;
        d = descs[slot];
        b = bufs[slot];
        for (int i = 0; i < 768; i++) put_byte(b + i, 8'hEE);
        mem[d / 4 + 1] = 32'(size);
        mem[d / 4]     = 32'h8000_0000;
        w0 = wr_cnt;
        mid_done = 0;
        k = 0;
        while (k < len) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = gen(fno, k);
            in_last  = (k == len - 1);
            if (k == stop_at) dma_start = 1'b0;
            if (mid && !mid_done && k == len / 2) begin
                mid_done = 1;
                chk(wr_cnt == w0 && get_byte(b) == 8'hEE, "R4 store-and-forward", wr_cnt - w0, 0);
            end
            if (in_ready) k++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        t = 0;
        while (mem[d / 4][31] && t < 20000) begin
            @(negedge clk);
            t++;
        end
        es = exp_status(size, len);
        chk(mem[d / 4] == es, req, mem[d / 4], es);
        st = int'(es[29:16]);
        ok = 1;
        for (int i = 0; i < st; i++)
            if (get_byte(b + i) != gen(fno, i)) ok = 0;
        chk(ok, "R4 buffer bytes", ok, 1);
        ok = 1;
        for (int i = st; i < 768; i++)
            if (get_byte(b + i) != 8'hEE) ok = 0;
        chk(ok, "R11 bytes after stored data untouched", ok, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ridx, fno, len, size, r0, seen_rdy, b0, nxt;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int s = 0; s < 3; s++) begin
            mem[descs[s] / 4 + 2] = 32'(bufs[s]);
            mem[descs[s] / 4 + 3] = 32'(descs[(s + 1) % 3]);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mem_req && !in_ready && !dma_busy, "R1 in reset", {mem_req, in_ready, dma_busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !in_ready && !dma_busy, "R1 after reset", {mem_req, in_ready, dma_busy}, 0);

        // R10: start alone does nothing
        dma_start = 1'b1;
        repeat (20) @(negedge clk);
        chk(req_cnt == 0 && !dma_busy, "R10 start without enable", req_cnt, 0);

        // R2: fetch order from base
        rx_enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(mem_req && !mem_we && mem_addr == BASE + 4 * i, "R2 descriptor fetch",
                mem_addr, BASE + 4 * i);
        end

        // R3: unowned descriptor holds input off and is re-read
        b0 = base_rd;
        seen_rdy = 0;
        in_valid = 1'b1;
        in_data  = 8'h11;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (in_ready) seen_rdy++;
        end
        in_valid = 1'b0;
        chk(seen_rdy == 0, "R3 input held while unowned", seen_rdy, 0);
        chk(base_rd - b0 >= 3, "R3 re-poll", base_rd - b0, 3);

        // directed frames
        fno = 0;
        run_frame(0, 2044, 100, fno++, "R5 normal status", -1, 1);
        run_frame(1, 2044, 10,  fno++, "R7 runt status", -1, 0);
        run_frame(2, 64,   80,  fno++, "R6 truncated status", -1, 1);
        run_frame(0, 10,   13,  fno++, "R8 ring wrap, R11 partial word", -1, 0);
        run_frame(1, 2044, 64,  fno++, "R7 64 bytes not runt", -1, 0);
        run_frame(2, 2044, 63,  fno++, "R7 63 bytes runt", -1, 0);
        ridx = 0;

        // random mix
        for (int n = 0; n < 12; n++) begin
            len  = 1 + int'($urandom % 700);
            size = (($urandom % 4) == 0) ? 1 + int'($urandom % 700) : 2044;
            run_frame(ridx, size, len, fno++, "R6 random frame status", -1, 1);
            ridx = (ridx + 1) % 3;
        end

        // R9: stop in mid-frame
        nxt = (ridx + 1) % 3;
        mem[descs[nxt] / 4 + 1] = 32'd2044;
        mem[descs[nxt] / 4]     = 32'h8000_0000;
        run_frame(ridx, 2044, 120, fno++, "R9 frame finished after stop", 60, 0);
        r0 = req_cnt;
        repeat (50) @(negedge clk);
        chk(req_cnt == r0, "R9 no access after stop", req_cnt - r0, 0);
        chk(!dma_busy, "R9 idle after stop", dma_busy, 0);
        chk(mem[descs[nxt] / 4] == 32'h8000_0000, "R9 next descriptor untouched",
            mem[descs[nxt] / 4], 32'h8000_0000);

        // R2: restart reloads from base
        dma_start = 1'b1;
        run_frame(0, 2044, 77, fno++, "R2 restart from base", -1, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule